// File: doc/BRIEF.md
# Linked-List 2D DMA Channel Engine

This block moves the data for a single DMA channel. A one-cycle `start` pulse loads a starting descriptor address. The engine then reads a six-word descriptor from memory and copies 32-bit words from a source address to a destination address. Each descriptor names the next one, so the engine works through a list of descriptors. A descriptor describes either a flat run of bytes or a rectangle made of rows. In the rectangle case, the source and the destination each have their own signed row step.

Every memory access goes through one master port with a request/acknowledge handshake, and at most one access is in flight. At the end of each descriptor the engine pulses an end flag, and it pulses an interrupt flag when the descriptor asks for one. It stops when the next address is zero, or when the channel enable is low at the point where a new descriptor would be fetched. Its working registers are visible on read-back outputs.

Top module: `dma_chain_engine`

## Requirements
- R1: After `start`, each descriptor is read as six words at byte offsets +0, +4, +8, +12, +16 and +20 from its address. The words are, in order: control word, source address, destination address, length word, step word and next-descriptor address.
- R2: When control bit 1 is 0 (flat mode), the whole length word is a byte count. The engine performs one read-then-write beat per 32-bit word.
- R3: When control bit 1 is 1 (rectangle mode), the row count is 1 + length[29:16] and the row byte count is length[15:0]. After every row except the last, the engine adds the sign-extended step word [15:0] to the source address and the sign-extended step word [31:16] to the destination address.
- R4: Control bit 11 replaces each source read with the data value zero, and no read is issued. Control bit 7 drops each destination write, and no write is issued.
- R5: Control bit 8 adds 4 to the source address after each beat. Control bit 4 adds 4 to the destination address after each beat. When the bit is clear, that address does not move.
- R6: `cur_len` is updated after each beat with the bytes left in the current row. In rectangle mode, bits [31:16] hold the rows left, counting the current row, and bits [15:0] hold the bytes left. In flat mode, the full word holds the bytes left.
- R7: `blk_end` pulses once per finished descriptor. `blk_irq` pulses in the same cycle only when control bit 0 is set.
- R8: After each descriptor, the next-descriptor address becomes the current address. The walk ends when that address is zero, or when `chan_en` is low at that point. `active` then falls and `paused` rises.
- R9: A `start` with `chan_en` low makes no memory access and ends at once with `active` low and `paused` high.
- R10: A request holds its address, direction and write data until it is acknowledged, and no request is made while `active` is low.
- R11: After reset, `active`, `paused`, `blk_end`, `blk_irq` and `mem_req` are all low.
- R12: A byte count that is not a multiple of 4 is rounded up to whole words, so 7 bytes take two beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a descriptor walk |
| chan_en | input | 1 | Channel enable, tested before each descriptor fetch |
| start_addr | input | ADDR_W | First descriptor address, taken on `start` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the current request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| active | output | 1 | Walk in progress |
| paused | output | 1 | Set when a walk has ended |
| blk_end | output | 1 | Pulse at the end of each descriptor |
| blk_irq | output | 1 | Interrupt pulse for descriptors that request it |
| cur_cb_addr | output | ADDR_W | Current descriptor address |
| cur_info | output | 32 | Current control word |
| cur_src | output | ADDR_W | Live source address |
| cur_dst | output | ADDR_W | Live destination address |
| cur_len | output | 32 | Live length word |
| cur_stride | output | 32 | Current step word |
| cur_next | output | ADDR_W | Next-descriptor address |

## Verification
The bench goes after these corner cases:

- **Negative row steps.** A design that added the steps unsigned, or after the last row as well, leaves the wrong final addresses and puts words in the wrong destination cells.
- **Odd byte counts.** A design that did not round up would run the counter past zero and copy without end, or lose the last partial word.
- **Zero-length rows.** A design that tested the count only after a beat would copy where nothing is due.
- **Skipped reads and writes.** A design that still issued them would show a different access count, or overwrite the destination.
- **Enable dropped during the first descriptor, or low at start.** A design that checked the enable in the wrong place would walk too far, or touch memory when it should not.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int CB_WORDS = 6;
    localparam int CB_IDX_W = $clog2(CB_WORDS);

    // control word bit positions
    localparam int CTL_IRQ   = 0;
    localparam int CTL_RECT  = 1;
    localparam int CTL_DINC  = 4;
    localparam int CTL_DSKIP = 7;
    localparam int CTL_SINC  = 8;
    localparam int CTL_SSKIP = 11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_FETCH, ST_SETUP, ST_STEP, ST_RD, ST_WR, ST_BLKEND
    } dma_state_e;

    typedef struct packed {
        logic irq_en;
        logic rect;
        logic d_inc;
        logic d_skip;
        logic s_inc;
        logic s_skip;
    } xfer_flags_t;

    function automatic xfer_flags_t decode_flags(input logic [31:0] ctl);
        xfer_flags_t f;
        f.irq_en = ctl[CTL_IRQ];
        f.rect   = ctl[CTL_RECT];
        f.d_inc  = ctl[CTL_DINC];
        f.d_skip = ctl[CTL_DSKIP];
        f.s_inc  = ctl[CTL_SINC];
        f.s_skip = ctl[CTL_SSKIP];
        return f;
    endfunction

    function automatic logic [31:0] round_words(input logic [31:0] bytes);
        return (bytes + 32'd3) & ~32'd3;
    endfunction

endpackage

// File: rtl/dma_cb_decode.sv
module dma_cb_decode
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       ctl,
    input  logic [31:0]       len,
    input  logic [31:0]       step,
    output xfer_flags_t       flags,
    output logic [15:0]       rows,
    output logic [31:0]       row_bytes,
    output logic [ADDR_W-1:0] src_step,
    output logic [ADDR_W-1:0] dst_step
);
    localparam int EXT_W = ADDR_W - 16;

    logic dec_unused;
    assign dec_unused = ^{ctl[31:12], ctl[10:9], ctl[6:5], ctl[3:2]};

    always_comb begin
        flags = decode_flags(ctl);
        if (flags.rect) begin
            rows      = 16'd1 + {2'b00, len[29:16]};
            row_bytes = round_words({16'h0000, len[15:0]});
            src_step  = {{EXT_W{step[15]}}, step[15:0]};
            dst_step  = {{EXT_W{step[31]}}, step[31:16]};
        end else begin
            rows      = 16'd1;
            row_bytes = round_words(len);
            src_step  = '0;
            dst_step  = '0;
        end
    end
endmodule

// File: rtl/dma_addr_adv.sv
module dma_addr_adv #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              inc_en,
    input  logic              beat,
    input  logic              row_wrap,
    input  logic [ADDR_W-1:0] row_step,
    output logic [ADDR_W-1:0] addr_nx
);
    always_comb begin
        addr_nx = addr;
        if (beat && inc_en) addr_nx = addr + ADDR_W'(4);
        if (row_wrap)       addr_nx = addr + row_step;
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              chan_en,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              active,
    output logic              paused,
    output logic              blk_end,
    output logic              blk_irq,
    output logic [ADDR_W-1:0] cur_cb_addr,
    output logic [31:0]       cur_info,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [31:0]       cur_len,
    output logic [31:0]       cur_stride,
    output logic [ADDR_W-1:0] cur_next
);
    dma_state_e          state;
    logic [CB_IDX_W-1:0] widx;
    logic [ADDR_W-1:0]   cb_addr, src_r, dst_r, next_r;
    logic [31:0]         info_r, len_r, stride_r, data_r;
    logic [15:0]         rows_left;
    logic [31:0]         rem, rowb_r, rem_m4;

    xfer_flags_t       flags;
    logic [15:0]       rows_dec;
    logic [31:0]       rowb_dec;
    logic [ADDR_W-1:0] s_step, d_step, src_nx, dst_nx;
    logic              beat_done, row_adv;

    dma_cb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ctl(info_r), .len(len_r), .step(stride_r), .flags(flags),
        .rows(rows_dec), .row_bytes(rowb_dec), .src_step(s_step), .dst_step(d_step)
    );

    assign beat_done = (state == ST_WR) && (flags.d_skip || mem_ack);
    assign row_adv   = (state == ST_STEP) && (rem == 32'd0) && (rows_left > 16'd1);
    assign rem_m4    = rem - 32'd4;

    dma_addr_adv #(.ADDR_W(ADDR_W)) u_src_adv (
        .addr(src_r), .inc_en(flags.s_inc), .beat(beat_done),
        .row_wrap(row_adv), .row_step(s_step), .addr_nx(src_nx)
    );
    dma_addr_adv #(.ADDR_W(ADDR_W)) u_dst_adv (
        .addr(dst_r), .inc_en(flags.d_inc), .beat(beat_done),
        .row_wrap(row_adv), .row_step(d_step), .addr_nx(dst_nx)
    );

    always_comb begin
        mem_req = (state == ST_FETCH) ||
                  (state == ST_RD && !flags.s_skip) ||
                  (state == ST_WR && !flags.d_skip);
        mem_we  = (state == ST_WR);
        case (state)
            ST_FETCH: mem_addr = cb_addr + (ADDR_W'(widx) << 2);
            ST_RD:    mem_addr = src_r;
            default:  mem_addr = dst_r;
        endcase
    end
    assign mem_wdata = data_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            widx      <= '0;
            active    <= 1'b0;
            paused    <= 1'b0;
            blk_end   <= 1'b0;
            blk_irq   <= 1'b0;
            cb_addr   <= '0;
            src_r     <= '0;
            dst_r     <= '0;
            next_r    <= '0;
            info_r    <= '0;
            len_r     <= '0;
            stride_r  <= '0;
            data_r    <= '0;
            rows_left <= '0;
            rem       <= '0;
            rowb_r    <= '0;
        end else begin
            blk_end <= 1'b0;
            blk_irq <= 1'b0;
            if (beat_done || row_adv) begin
                src_r <= src_nx;
                dst_r <= dst_nx;
            end
            case (state)
                ST_IDLE: if (start) begin
                    active  <= 1'b1;
                    paused  <= 1'b0;
                    cb_addr <= start_addr;
                    state   <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (chan_en && cb_addr != '0) begin
                        widx  <= '0;
                        state <= ST_FETCH;
                    end else begin
                        active <= 1'b0;
                        paused <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_FETCH: if (mem_ack) begin
                    case (widx)
                        3'd0:    info_r   <= mem_rdata;
                        3'd1:    src_r    <= mem_rdata[ADDR_W-1:0];
                        3'd2:    dst_r    <= mem_rdata[ADDR_W-1:0];
                        3'd3:    len_r    <= mem_rdata;
                        3'd4:    stride_r <= mem_rdata;
                        default: next_r   <= mem_rdata[ADDR_W-1:0];
                    endcase
                    if (widx == CB_IDX_W'(CB_WORDS - 1)) state <= ST_SETUP;
                    else widx <= widx + 1'b1;
                end
                ST_SETUP: begin
                    rows_left <= rows_dec;
                    rem       <= rowb_dec;
                    rowb_r    <= rowb_dec;
                    state     <= ST_STEP;
                end
                ST_STEP: begin
                    if (rem != 32'd0) begin
                        state <= ST_RD;
                    end else if (rows_left > 16'd1) begin
                        rows_left <= rows_left - 16'd1;
                        rem       <= rowb_r;
                    end else begin
                        state <= ST_BLKEND;
                    end
                end
                ST_RD: begin
                    if (flags.s_skip) begin
                        data_r <= 32'd0;
                        state  <= ST_WR;
                    end else if (mem_ack) begin
                        data_r <= mem_rdata;
                        state  <= ST_WR;
                    end
                end
                ST_WR: if (beat_done) begin
                    rem   <= rem_m4;
                    len_r <= flags.rect ? {rows_left, rem_m4[15:0]} : rem_m4;
                    state <= ST_STEP;
                end
                ST_BLKEND: begin
                    blk_end <= 1'b1;
                    blk_irq <= flags.irq_en;
                    cb_addr <= next_r;
                    state   <= ST_CHECK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cur_cb_addr = cb_addr;
    assign cur_info    = info_r;
    assign cur_src     = src_r;
    assign cur_dst     = dst_r;
    assign cur_len     = len_r;
    assign cur_stride  = stride_r;
    assign cur_next    = next_r;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mem_req);
    // R7
    irq_with_end_chk: assert property (@(posedge clk) disable iff (rst)
        blk_irq |-> blk_end);
    // R8
    stop_paused_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> paused);
    // R7
    end_single_chk: assert property (@(posedge clk) disable iff (rst)
        blk_end |=> !blk_end);
    // R12
    rem_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_STEP |-> rem[1:0] == 2'b00);
endmodule

// File: tb/dma_chain_engine_tb.sv
module dma_chain_engine_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic chan_en = 1'b1;
    logic [31:0] start_addr = '0;
    logic mem_req, mem_we, mem_ack, active, paused, blk_end, blk_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] cur_cb_addr, cur_info, cur_src, cur_dst, cur_len, cur_stride, cur_next;

    always #4 clk = ~clk;   // 125 MHz

    dma_chain_engine #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst), .start(start), .chan_en(chan_en), .start_addr(start_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .active(active), .paused(paused),
        .blk_end(blk_end), .blk_irq(blk_irq), .cur_cb_addr(cur_cb_addr), .cur_info(cur_info),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_len(cur_len), .cur_stride(cur_stride),
        .cur_next(cur_next)
    );

    logic [31:0] mem [0:1023];
    logic [31:0] exp_mem [0:1023];
    int n_chk = 0, n_bad = 0;
    int n_rd = 0, n_wr = 0, n_blk = 0, n_irq = 0, wait_cnt = 0;

    function automatic int ix(input logic [31:0] a);
        return int'(a[11:2]);
    endfunction

    // memory model: one access at a time, 0 to 2 wait cycles
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[ix(mem_addr)] = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata <= mem[ix(mem_addr)];
                    n_rd++;
                end
                wait_cnt = int'($urandom % 3);
            end else begin
                wait_cnt--;
            end
        end
        if (!rst && blk_end) n_blk++;
        if (!rst && blk_irq) n_irq++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic put_cb(input logic [31:0] a, input logic [31:0] ctl, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] l, input logic [31:0] st,
                          input logic [31:0] nx);
        mem[ix(a)] = ctl;      mem[ix(a + 4)] = s;   mem[ix(a + 8)] = d;
        mem[ix(a + 12)] = l;   mem[ix(a + 16)] = st; mem[ix(a + 20)] = nx;
    endtask

    // expected results of a walk
    int e_rd, e_wr, e_blk, e_irq;
    logic [31:0] e_src, e_dst, e_len, e_cb, e_info, e_next;

    task automatic model(input logic [31:0] first, input int limit);
        logic [31:0] cb, ctl, s, d, l, st, nx, rb, rem, data, ss, ds;
        int rows;
        cb = first; e_rd = 0; e_wr = 0; e_blk = 0; e_irq = 0;
        while (cb != 0 && e_blk < limit) begin
            ctl = exp_mem[ix(cb)];      s = exp_mem[ix(cb + 4)];   d = exp_mem[ix(cb + 8)];
            l = exp_mem[ix(cb + 12)];   st = exp_mem[ix(cb + 16)]; nx = exp_mem[ix(cb + 20)];
            e_rd += 6;
            if (ctl[1]) begin
                rows = 1 + int'(l[29:16]);
                rb = ({16'h0, l[15:0]} + 32'd3) & ~32'd3;
                ss = {{16{st[15]}}, st[15:0]};
                ds = {{16{st[31]}}, st[31:16]};
            end else begin
                rows = 1; rb = (l + 32'd3) & ~32'd3; ss = 0; ds = 0;
            end
            for (int r = 0; r < rows; r++) begin
                rem = rb;
                while (rem != 0) begin
                    if (ctl[11]) data = 0;
                    else begin data = exp_mem[ix(s)]; e_rd++; end
                    if (!ctl[7]) begin exp_mem[ix(d)] = data; e_wr++; end
                    if (ctl[8]) s += 4;
                    if (ctl[4]) d += 4;
                    rem -= 4;
                    l = ctl[1] ? {16'(rows - r), rem[15:0]} : rem;
                end
                if (r != rows - 1) begin s += ss; d += ds; end
            end
            e_blk++;
            if (ctl[0]) e_irq++;
            e_src = s; e_dst = d; e_len = l; e_info = ctl; e_next = nx;
            cb = nx;
        end
        e_cb = cb;
    endtask

    task automatic run_walk(input string tag, input logic [31:0] first, input logic en0,
                            input int drop_after, input int limit);
        int bad_words, tmo;
        for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
        @(negedge clk);
        n_rd = 0; n_wr = 0; n_blk = 0; n_irq = 0;
        chan_en = en0; start_addr = first; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tmo = 0;
        while (active && tmo < 20000) begin
            @(negedge clk);
            tmo++;
            if (tmo == drop_after) chan_en = 1'b0;
        end
        chk({tag, " R8 walk ends (timeout flag)"}, 32'(tmo >= 20000), 32'd0);
        model(first, en0 ? limit : 0);
        chk({tag, " R8 active low, paused high"}, {30'd0, active, paused}, 32'd1);
        chk({tag, " R7 end pulses"}, 32'(n_blk), 32'(e_blk));
        chk({tag, " R7 irq pulses"}, 32'(n_irq), 32'(e_irq));
        chk({tag, " R1 R4 read count"}, 32'(n_rd), 32'(e_rd));
        chk({tag, " R4 write count"}, 32'(n_wr), 32'(e_wr));
        chk({tag, " R8 final descriptor address"}, cur_cb_addr, en0 ? e_cb : first);
        if (e_blk > 0) begin
            chk({tag, " R3 R5 final source"}, cur_src, e_src);
            chk({tag, " R3 R5 final destination"}, cur_dst, e_dst);
            chk({tag, " R6 live length"}, cur_len, e_len);
            chk({tag, " R1 control readback"}, cur_info, e_info);
            chk({tag, " R1 next readback"}, cur_next, e_next);
        end
        bad_words = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) bad_words++;
        chk({tag, " R2 R3 memory image"}, 32'(bad_words), 32'd0);
        chan_en = 1'b1;
    endtask

    task automatic fill_data();
        for (int i = 0; i < 1024; i++) mem[i] = (i >= 256) ? $urandom : 32'd0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill_data();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset outputs", {27'd0, active, paused, blk_end, blk_irq, mem_req}, 32'd0);

        // R2 R5 R7 flat, both increment, irq
        put_cb(32'h40, 32'h0000_0111, 32'h400, 32'h900, 32'd16, 32'd0, 32'd0);
        run_walk("flat16", 32'h40, 1'b1, 0, 1000);

        // R12 flat, 7 bytes rounds to two beats, no irq, fixed destination
        put_cb(32'h40, 32'h0000_0100, 32'h420, 32'h940, 32'd7, 32'd0, 32'd0);
        run_walk("flat7", 32'h40, 1'b1, 0, 1000);

        // R3 R6 rectangle, 3 rows of 8 bytes, src +8, dst -24
        put_cb(32'h40, 32'h0000_0113, 32'h440, 32'hA00, 32'h0002_0008, 32'hFFE8_0008, 32'h60);
        // R4 R3 rectangle with both skips and zero-length rows, chained
        put_cb(32'h60, 32'h0000_0993, 32'h480, 32'hA40, 32'h0001_0000, 32'h0010_FFF0, 32'h80);
        // R4 skip read only: writes zero
        put_cb(32'h80, 32'h0000_0811, 32'h4C0, 32'hA80, 32'd12, 32'd0, 32'd0);
        run_walk("rect_chain", 32'h40, 1'b1, 0, 1000);

        // R9 start with enable low
        run_walk("en_low", 32'h40, 1'b0, 0, 0);

        // R8 enable dropped during the first descriptor
        put_cb(32'h40, 32'h0000_0111, 32'h400, 32'h900, 32'd8, 32'd0, 32'h60);
        put_cb(32'h60, 32'h0000_0111, 32'h410, 32'h910, 32'd8, 32'd0, 32'd0);
        run_walk("en_drop", 32'h40, 1'b1, 3, 1);

        // constrained random walks: R2 R3 R4 R5 R6 R7 R12
        for (int t = 0; t < 24; t++) begin
            int nb;
            fill_data();
            nb = 1 + int'($urandom % 3);
            for (int k = 0; k < nb; k++) begin
                logic [31:0] ctl, len, st, nx;
                ctl = 0;
                ctl[0] = $urandom % 2;
                ctl[1] = $urandom % 2;
                ctl[4] = ($urandom % 4) != 0;
                ctl[8] = ($urandom % 4) != 0;
                ctl[7] = ($urandom % 6) == 0;
                ctl[11] = ($urandom % 6) == 0;
                if (ctl[1]) begin
                    len = {2'b00, 14'($urandom % 4), 16'($urandom % 17)};
                    st = {16'(int'($urandom % 33) - 16), 16'(int'($urandom % 33) - 16)};
                end else begin
                    len = $urandom % 41;
                    st = $urandom;
                end
                nx = (k == nb - 1) ? 32'd0 : 32'h40 + 32'(32 * (k + 1));
                put_cb(32'h40 + 32'(32 * k), ctl, 32'h400 + 32'(4 * ($urandom % 64)),
                       32'h900 + 32'(4 * ($urandom % 64)), len, st, nx);
            end
            run_walk($sformatf("rand%0d", t), 32'h40, 1'b1, 0, 1000);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R8: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule